// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block watches the access strobes of an asynchronous-style SRAM port (a 13-bit address, an active-low chip enable and an active-low write enable), all sampled in one clock domain. It looks for two fixed runs of six read addresses. One run requests a nonvolatile store and the other requests a recall. A completed run produces a one-clock start pulse for the matching engine. It also raises an I/O-disable output that keeps the SRAM interface shut for the length of that operation. The store and recall engines are outside this block.

A read step is the synchronous detection of chip enable going from high to low while write enable is high. Each run has its own step counter, so a shared prefix moves both counters forward at once. If a read does not match the next expected address of a run, or if a write arrives, that run goes back to its idle step and no command is issued. Output enable has no part in recognition, so it is not an input. The lockout is a three-state machine. The states are `LK_IDLE`, `LK_STORE` and `LK_RECALL`. The transitions are idle→store on a store match, idle→recall on a recall match when there is no store match, and store→idle or recall→idle when the lockout counter reaches zero.

The recall run always begins with the store run's first two addresses. Its last four addresses are parameters. The two lockout lengths are parameters counted in clock cycles. Their defaults are 10 ms and 20 µs at 200 MHz.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After reset, and while `rst_n` is low, `store_start`, `recall_start` and `io_disable` are 0. A reset also clears any partial progress, so a run must restart from its first address.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F in that order raise `store_start` for exactly one clock. The pulse comes after the second rising edge that follows the sixth chip-enable fall (one edge to sample the fall, one to register the pulse).
- R3: With default parameters, reads of 0x0000, 0x1555, 0x0E38, 0x11C7, 0x0C63, 0x139C in that order raise `recall_start` for exactly one clock, with the same timing as R2.
- R4: Only a high-to-low transition of `ce_n` while `we_n` is high counts as a read step. Address changes while `ce_n` stays low are ignored.
- R5: A read whose address is not the next expected entry returns that run to its idle step. The aborting read is not counted as a first step, even when it is 0x0000.
- R6: A write aborts both runs. A write is `we_n` low when `ce_n` falls, or `we_n` falling while `ce_n` is low.
- R7: Reading the same step address twice in a row (double clocking) aborts the run.
- R8: `io_disable` rises together with a start pulse. It stays high for exactly `STORE_LOCK_CYC` clocks after a store and for exactly `RECALL_LOCK_CYC` clocks after a recall.
- R9: While `io_disable` is high, accesses make no progress and produce no command. Both runs are at their idle step when it falls.
- R10: The two runs are tracked independently. A read that advances one run while aborting the other still lets the first run complete.
- R11: `store_start` and `recall_start` are never high together. If both runs complete on the same read, only the store is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_addr | input | 13 | SRAM address bus |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| store_start | output | 1 | One-clock request to start a nonvolatile store |
| recall_start | output | 1 | One-clock request to start a recall |
| io_disable | output | 1 | High while the SRAM interface is locked out |

## Verification
The read that ends one run can be the same read that aborts the other. Also, with identical tables, both runs can end on the same read. The first case is provoked by the store run: its third read is also the point where the recall run diverges, and the check is that only the store pulse appears and a later recall run still completes. The second case uses a second instance whose recall table equals the store table. It sees the same store run, and the check is that it pulses `store_start` alone, with `recall_start` held low in the same cycle.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    localparam int ADDR_W  = 13;
    localparam int SEQ_LEN = 6;

    // Entry i sits at bits [i*ADDR_W +: ADDR_W]; entry 0 is read first.
    localparam logic [SEQ_LEN*ADDR_W-1:0] STORE_TABLE = {
        13'h0F0F, 13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000
    };

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_STORE  = 2'd1,
        LK_RECALL = 2'd2
    } lock_state_t;

endpackage

// File: rtl/nvcmd_edge.sv
module nvcmd_edge #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          ce_n,
    input  logic          we_n,
    output logic [AW-1:0] addr_q,
    output logic          rd_evt,
    output logic          wr_evt
);

    logic ce_d1, ce_d2, we_d1, we_d2;
    logic ce_fall, we_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d1  <= 1'b1;
            ce_d2  <= 1'b1;
            we_d1  <= 1'b1;
            we_d2  <= 1'b1;
            addr_q <= '0;
        end else begin
            ce_d1  <= ce_n;
            ce_d2  <= ce_d1;
            we_d1  <= we_n;
            we_d2  <= we_d1;
            addr_q <= addr_in;
        end
    end

    always_comb begin
        ce_fall = ce_d2 & ~ce_d1;
        we_fall = we_d2 & ~we_d1;
        rd_evt  = ce_fall & we_d1;
        wr_evt  = (ce_fall & ~we_d1) | (we_fall & ~ce_d1);
    end

    // R6: an access is never classified as both read and write
    assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt && wr_evt));

    // R4: a chip enable held low yields no further read step
    assert_held_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ce_d1) |=> !rd_evt);

endmodule

// File: rtl/nvcmd_track.sv
module nvcmd_track #(
    parameter int AW  = 13,
    parameter int LEN = 6,
    parameter logic [LEN*AW-1:0] SEQ = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic          hold,
    input  logic [AW-1:0] addr,
    output logic          hit
);

    localparam int STEP_W = $clog2(LEN);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(LEN - 1);

    logic [AW-1:0]     tbl [LEN];
    logic [STEP_W-1:0] step;
    logic [AW-1:0]     want;
    logic              match, go;

    for (genvar i = 0; i < LEN; i++) begin : g_entry
        assign tbl[i] = SEQ[i*AW +: AW];
    end

    always_comb begin
        want  = tbl[step];
        match = (addr == want);
        go    = rd_evt && !hold;
        hit   = go && match && (step == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (hold || wr_evt) begin
            step <= '0;
        end else if (go) begin
            if (match && step != LAST) step <= step + 1'b1;
            else                       step <= '0;
        end
    end

    assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST);

    assert_mismatch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !match) |=> step == '0);

    assert_write_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> step == '0);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> step == '0);

    assert_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && match && step != LAST) |=> step == $past(step) + 1'b1);

endmodule

// File: rtl/nvcmd_lock.sv
module nvcmd_lock
    import nvcmd_pkg::*;
#(
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 4_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_hit,
    input  logic recall_hit,
    output logic store_start,
    output logic recall_start,
    output logic io_disable
);

    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STORE_LOAD  = CNT_W'(STORE_CYC - 1);
    localparam logic [CNT_W-1:0] RECALL_LOAD = CNT_W'(RECALL_CYC - 1);

    lock_state_t       st, st_d;
    logic [CNT_W-1:0]  cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= LK_IDLE;
        else        st <= st_d;
    end

    // next state
    always_comb begin
        st_d = st;
        unique case (st)
            LK_IDLE: begin
                if (store_hit)       st_d = LK_STORE;
                else if (recall_hit) st_d = LK_RECALL;
            end
            LK_STORE, LK_RECALL: begin
                if (cnt == '0) st_d = LK_IDLE;
            end
            default: st_d = LK_IDLE;
        endcase
    end

    // outputs and lockout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_start  <= 1'b0;
            recall_start <= 1'b0;
            cnt          <= '0;
        end else begin
            store_start  <= (st == LK_IDLE) && store_hit;
            recall_start <= (st == LK_IDLE) && recall_hit && !store_hit;
            unique case (st)
                LK_IDLE: begin
                    if (store_hit)       cnt <= STORE_LOAD;
                    else if (recall_hit) cnt <= RECALL_LOAD;
                end
                default: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign io_disable = (st != LK_IDLE);

    assert_single_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_start, recall_start}));

    assert_store_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> !store_start);

    assert_recall_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start |=> !recall_start);

    assert_start_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> io_disable);

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_disable && cnt != '0) |=> io_disable);

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
#(
    parameter int STORE_LOCK_CYC  = 2_000_000,
    parameter int RECALL_LOCK_CYC = 4_000,
    parameter logic [ADDR_W-1:0] RECALL_A2 = 13'h0E38,
    parameter logic [ADDR_W-1:0] RECALL_A3 = 13'h11C7,
    parameter logic [ADDR_W-1:0] RECALL_A4 = 13'h0C63,
    parameter logic [ADDR_W-1:0] RECALL_A5 = 13'h139C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              ce_n,
    input  logic              we_n,
    output logic              store_start,
    output logic              recall_start,
    output logic              io_disable
);

    localparam int NSEQ = 2;
    localparam logic [SEQ_LEN*ADDR_W-1:0] RECALL_TABLE = {
        RECALL_A5, RECALL_A4, RECALL_A3, RECALL_A2, STORE_TABLE[2*ADDR_W-1:0]
    };
    // index 0: store, index 1: recall
    localparam logic [NSEQ-1:0][SEQ_LEN*ADDR_W-1:0] TABLES = {RECALL_TABLE, STORE_TABLE};

    logic [ADDR_W-1:0] addr_q;
    logic              rd_evt, wr_evt;
    logic [NSEQ-1:0]   hits;

    nvcmd_edge #(.AW(ADDR_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_in (cmd_addr),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr_q  (addr_q),
        .rd_evt  (rd_evt),
        .wr_evt  (wr_evt)
    );

    for (genvar g = 0; g < NSEQ; g++) begin : g_trk
        nvcmd_track #(
            .AW  (ADDR_W),
            .LEN (SEQ_LEN),
            .SEQ (TABLES[g])
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_evt (rd_evt),
            .wr_evt (wr_evt),
            .hold   (io_disable),
            .addr   (addr_q),
            .hit    (hits[g])
        );
    end

    nvcmd_lock #(
        .STORE_CYC  (STORE_LOCK_CYC),
        .RECALL_CYC (RECALL_LOCK_CYC)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_hit    (hits[0]),
        .recall_hit   (hits[1]),
        .store_start  (store_start),
        .recall_start (recall_start),
        .io_disable   (io_disable)
    );

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_disable |-> (hits == '0));

    assert_write_no_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !(store_start || recall_start));

endmodule

// File: tb/tb_nvcmd_seq_detect.sv
`timescale 1ns/1ps
module tb_nvcmd_seq_detect;

    localparam int SL = 50;
    localparam int RL = 20;
    localparam int NV = 47;

    // [15] we_n, [14] expect store, [13] expect recall, [12:0] address
    localparam logic [15:0] VEC [NV] = '{
        16'h8000, 16'h9555, 16'h8AAA, 16'h9FFF, 16'h90F0, 16'hCF0F,              // store, recall diverges
        16'h8000, 16'h9555, 16'h8E38, 16'h91C7, 16'h8C63, 16'hB39C,              // recall
        16'h8000, 16'h9555, 16'h8AAA, 16'h8123, 16'h9FFF, 16'h90F0, 16'h8F0F,    // stray read
        16'h8000, 16'h9555, 16'h0AAA, 16'h8AAA, 16'h9FFF, 16'h90F0, 16'h8F0F,    // write
        16'h8000, 16'h9555, 16'h9555, 16'h8AAA, 16'h9FFF, 16'h90F0, 16'h8F0F,    // double clock
        16'h8000, 16'h9555, 16'h8000, 16'h9555, 16'h8AAA, 16'h9FFF, 16'h90F0, 16'h8F0F,
        16'h8000, 16'h9555, 16'h8AAA, 16'h9FFF, 16'h90F0, 16'hCF0F               // store again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cmd_addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        store_start, recall_start, io_disable;
    logic        eq_store, eq_recall, eq_io;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic s_st, s_rc, s_io, s_est, s_erc;

    always #2.5 clk = ~clk;

    nvcmd_seq_detect #(.STORE_LOCK_CYC(SL), .RECALL_LOCK_CYC(RL)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .ce_n(ce_n), .we_n(we_n),
        .store_start(store_start), .recall_start(recall_start), .io_disable(io_disable)
    );

    nvcmd_seq_detect #(
        .STORE_LOCK_CYC(SL), .RECALL_LOCK_CYC(RL),
        .RECALL_A2(13'h0AAA), .RECALL_A3(13'h1FFF), .RECALL_A4(13'h10F0), .RECALL_A5(13'h0F0F)
    ) dut_eq (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .ce_n(ce_n), .we_n(we_n),
        .store_start(eq_store), .recall_start(eq_recall), .io_disable(eq_io)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one access: ce_n falls at a negedge, sample after the second rising edge
    task automatic access(input logic [12:0] a, input logic w);
        @(negedge clk);
        cmd_addr = a; we_n = w; ce_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        s_st = store_start; s_rc = recall_start; s_io = io_disable;
        s_est = eq_store; s_erc = eq_recall;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    // counts io_disable cycles; the sample taken in access() was the first
    task automatic wait_lock(input int exp_len, input string tag);
        int n = 1;
        chk(s_io == 1'b1, {tag, " lock rises with pulse"}, int'(s_io), 1);
        for (int k = 0; k < 1000; k++) begin
            @(posedge clk); #1;
            if (k == 0)
                chk(!store_start && !recall_start, "R2 R3 pulse lasts one cycle",
                    int'(store_start) + int'(recall_start), 0);
            if (io_disable) n++;
            else break;
        end
        chk(n == exp_len, {tag, " lock length"}, n, exp_len);
    endtask

    function automatic string vtag(input int i);
        if (i < 6)  return "R2,R10";
        if (i < 12) return "R3";
        if (i < 19) return "R5";
        if (i < 26) return "R6";
        if (i < 33) return "R7";
        if (i < 41) return "R5";
        return "R2";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!store_start && !recall_start && !io_disable, "R1 outputs during reset",
            int'({store_start, recall_start, io_disable}), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(!store_start && !recall_start && !io_disable, "R1 outputs after reset",
            int'({store_start, recall_start, io_disable}), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][12:0], VEC[i][15]);
            chk(s_st == VEC[i][14], {vtag(i), " store_start"}, int'(s_st), int'(VEC[i][14]));
            chk(s_rc == VEC[i][13], {vtag(i), " recall_start"}, int'(s_rc), int'(VEC[i][13]));
            if (VEC[i][14]) begin
                chk(s_est && !s_erc, "R11 equal tables start store only",
                    int'({s_est, s_erc}), 2);
                wait_lock(SL, "R8 store");
            end
            if (VEC[i][13]) wait_lock(RL, "R8 recall");
        end

        // R1: reset clears partial progress
        access(13'h0000, 1'b1); access(13'h1555, 1'b1); access(13'h0AAA, 1'b1);
        access(13'h1FFF, 1'b1); access(13'h10F0, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        access(13'h0F0F, 1'b1);
        chk(!s_st, "R1 reset discards progress", int'(s_st), 0);

        // R4: address changes while ce_n held low do not step
        @(negedge clk);
        cmd_addr = 13'h0000; ce_n = 1'b0;
        repeat (3) @(posedge clk);
        begin
            logic [12:0] rest [5] = '{13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0F};
            for (int j = 0; j < 5; j++) begin
                @(negedge clk) cmd_addr = rest[j];
                repeat (3) @(posedge clk);
                #1;
                chk(!store_start, "R4 held ce_n no command", int'(store_start), 0);
            end
        end
        @(negedge clk) ce_n = 1'b1;
        access(13'h1555, 1'b1); access(13'h0AAA, 1'b1); access(13'h1FFF, 1'b1);
        access(13'h10F0, 1'b1); access(13'h0F0F, 1'b1);
        chk(s_st, "R4 only the first fall counted as step one", int'(s_st), 1);
        wait_lock(SL, "R8 store");

        // R6: we_n falling while ce_n is low aborts
        access(13'h0000, 1'b1); access(13'h1555, 1'b1);
        @(negedge clk);
        cmd_addr = 13'h0AAA; ce_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) we_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        access(13'h1FFF, 1'b1); access(13'h10F0, 1'b1); access(13'h0F0F, 1'b1);
        chk(!s_st, "R6 late write aborts store", int'(s_st), 0);

        // R9: accesses during the lockout are ignored
        access(13'h0000, 1'b1); access(13'h1555, 1'b1); access(13'h0AAA, 1'b1);
        access(13'h1FFF, 1'b1); access(13'h10F0, 1'b1); access(13'h0F0F, 1'b1);
        chk(s_st, "R9 setup store", int'(s_st), 1);
        begin
            logic [12:0] rc [6] = '{13'h0000, 13'h1555, 13'h0E38, 13'h11C7, 13'h0C63, 13'h139C};
            for (int j = 0; j < 6; j++) begin
                access(rc[j], 1'b1);
                chk(!s_rc && s_io, "R9 recall run inside lockout", int'({s_rc, s_io}), 1);
            end
            for (int k = 0; k < 200 && io_disable; k++) @(posedge clk);
            for (int j = 1; j < 6; j++) access(rc[j], 1'b1);
            chk(!s_rc, "R9 idle after lockout", int'(s_rc), 0);
            for (int j = 0; j < 6; j++) access(rc[j], 1'b1);
            chk(s_rc && !s_st, "R3 recall after lockout", int'({s_rc, s_st}), 2);
            chk(!s_erc, "R11 equal-table instance no recall", int'(s_erc), 0);
            wait_lock(RL, "R8 recall");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule